// File: doc/BRIEF.md
# Instruction Address Breakpoint Interrupt Unit

This unit compares the start address of every instruction that is about to run against a small set of programmable breakpoint addresses. When an enabled channel's address equals the address presented with the instruction-start strobe, the unit sends an interrupt request to the core before that instruction executes. It also reports which channel matched and gives the program-counter value that the core's stacking sequence must push.

The request is deliberately separate from the core's global interrupt-enable flag and its current priority level. The unit has no input for either of them. The pushed value is the breakpoint address plus a small offset. The offset depends on a one-bit opcode-length class from the decoder: plus two for the long class and plus one otherwise. This value is not a usable return address. The handler must repair the stack or return by a jump, and the unit makes no attempt to correct the value.

Software uses a small register port to set the channels. Each channel has one address register, and one enable register holds one bit per channel. Writes take effect at the clock edge. Reads return the register selected in the previous cycle.

Top module: `addr_watch_irq`

## Requirements
- R1: After synchronous reset, all breakpoint address registers and all enable bits are zero, `irq_req` is 0, and `cfg_rdata` reads zero for every select code.
- R2: When `insn_start` is 1, channel i's enable bit is 1 and `insn_addr` equals channel i's address, `irq_req` is 1 in the next cycle only, as a one-cycle pulse. No interrupt flag or priority input takes part in this decision.
- R3: A channel whose enable bit is 0 never causes a request, even when its address equals `insn_addr` on a strobe.
- R4: No request occurs in a cycle after `insn_start` was 0, whatever the address and enable settings are.
- R5: When several enabled channels match on one strobe, a single pulse is issued and `irq_chan` gives the lowest matching channel index (channel 0 wins over channel 1).
- R6: With a request, `stack_pc` equals the strobed address plus 2 when `insn_long` was 1, and plus 1 when it was 0. The sum wraps modulo 2^ADDR_W.
- R7: Select code 0 addresses channel 0's address register, code 1 addresses channel 1's, and code NUM_CH (2) addresses the enable register. In the enable register, bit 0 belongs to channel 0 and bit 1 to channel 1. Its other bits are ignored on write and read as zero. Code 3 reads zero. `cfg_rdata` returns the registered value of the register selected one cycle earlier.
- R8: A configuration write in the same cycle as a strobe does not affect that strobe's comparison. The comparison uses the register contents from before the write.
- R9: `irq_chan` and `stack_pc` change only together with a request, and otherwise hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select (0, 1: address registers; 2: enable register) |
| cfg_wdata | input | 20 | Write data |
| cfg_rdata | output | 20 | Registered read data of the register selected one cycle earlier |
| insn_start | input | 1 | Marks the cycle in which a new instruction is about to start |
| insn_addr | input | 20 | Start address of that instruction |
| insn_long | input | 1 | Opcode-length class from the decoder (1 = offset of 2) |
| irq_req | output | 1 | One-cycle interrupt request pulse |
| irq_chan | output | 1 | Index of the channel that caused the request |
| stack_pc | output | 20 | Program-counter value to push for the request |

## Verification
The hardest cases to reach from the ports are two enabled channels holding the same address and hit on one strobe, and a register write that lands in the same cycle as a strobe aimed at the new value. Random addresses almost never produce either case. The stimulus therefore draws most strobe addresses from the currently programmed registers, randomizes the enable pattern and the write timing against those strobes, and also adds directed steps that load both channels with one address and retarget a channel in the strobe cycle. A further directed step puts a breakpoint at the top of the address space, so the plus-two offset has to wrap.

// File: rtl/awi_pkg.sv
package awi_pkg;
  // Program-counter offsets per opcode-length class
  localparam int unsigned OFFSET_SHORT = 1;
  localparam int unsigned OFFSET_LONG  = 2;
endpackage

// File: rtl/awi_regs.sv
module awi_regs #(
  parameter int ADDR_W = 20,
  parameter int NUM_CH = 2,
  parameter int SEL_W  = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_wr,
  input  logic [SEL_W-1:0]               cfg_sel,
  input  logic [ADDR_W-1:0]              cfg_wdata,
  output logic [ADDR_W-1:0]              cfg_rdata,
  output logic [NUM_CH-1:0][ADDR_W-1:0]  match_q,
  output logic [NUM_CH-1:0]              en_q
);

  logic [ADDR_W-1:0] rd_mux;

  // one address register per channel
  for (genvar c = 0; c < NUM_CH; c++) begin : g_addr
    always_ff @(posedge clk) begin
      if (rst) begin
        match_q[c] <= '0;
      end else if (cfg_wr && (int'(cfg_sel) == c)) begin
        match_q[c] <= cfg_wdata;
      end
    end
  end

  // enable register sits right after the address registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (cfg_wr && (int'(cfg_sel) == NUM_CH)) begin
      en_q <= cfg_wdata[NUM_CH-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (int'(cfg_sel) == c) rd_mux = match_q[c];
    end
    if (int'(cfg_sel) == NUM_CH) rd_mux = {{(ADDR_W-NUM_CH){1'b0}}, en_q};
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_mux;
  end

endmodule

// File: rtl/awi_cmp.sv
module awi_cmp #(
  parameter int ADDR_W = 20
) (
  input  logic              strobe,
  input  logic              enable,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] target,
  output logic              hit
);
  assign hit = strobe && enable && (addr == target);
endmodule

// File: rtl/awi_pick.sv
module awi_pick #(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic [NUM_CH-1:0] hit_vec,
  output logic              any_hit,
  output logic [CH_W-1:0]   win_idx
);
  // scan from top down so the lowest index is the last one assigned and wins
  always_comb begin
    any_hit = 1'b0;
    win_idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        any_hit = 1'b1;
        win_idx = CH_W'(i);
      end
    end
  end
endmodule

// File: rtl/addr_watch_irq.sv
module addr_watch_irq #(
  parameter int ADDR_W = 20,
  parameter int NUM_CH = 2,
  parameter int SEL_W  = $clog2(NUM_CH + 2),
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              insn_start,
  input  logic [ADDR_W-1:0] insn_addr,
  input  logic              insn_long,
  output logic              irq_req,
  output logic [CH_W-1:0]   irq_chan,
  output logic [ADDR_W-1:0] stack_pc
);
  import awi_pkg::*;

  logic [NUM_CH-1:0][ADDR_W-1:0] match_q;
  logic [NUM_CH-1:0]             en_q;
  logic [NUM_CH-1:0]             hit_vec;
  logic                          any_hit;
  logic [CH_W-1:0]               win_idx;
  logic [ADDR_W-1:0]             push_val;

  awi_regs #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .SEL_W(SEL_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .match_q   (match_q),
    .en_q      (en_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    awi_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .strobe (insn_start),
      .enable (en_q[c]),
      .addr   (insn_addr),
      .target (match_q[c]),
      .hit    (hit_vec[c])
    );
  end

  awi_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
    .hit_vec (hit_vec),
    .any_hit (any_hit),
    .win_idx (win_idx)
  );

  assign push_val = insn_addr + (insn_long ? ADDR_W'(OFFSET_LONG) : ADDR_W'(OFFSET_SHORT));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req  <= 1'b0;
      irq_chan <= '0;
      stack_pc <= '0;
    end else begin
      irq_req <= any_hit;
      if (any_hit) begin
        irq_chan <= win_idx;
        stack_pc <= push_val;
      end
    end
  end

endmodule

// File: rtl/awi_chk.sv
module awi_chk #(
  parameter int ADDR_W = 20,
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              insn_start,
  input logic [ADDR_W-1:0] insn_addr,
  input logic              insn_long,
  input logic [NUM_CH-1:0] en_q,
  input logic [NUM_CH-1:0] hit_vec,
  input logic              irq_req,
  input logic [CH_W-1:0]   irq_chan,
  input logic [ADDR_W-1:0] stack_pc
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_req && en_q == '0));

  // R4
  strobe_needed_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> $past(insn_start));

  // R3
  enabled_only_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> |($past(en_q) & (NUM_CH'(1) << irq_chan)));

  // R5
  lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (($past(hit_vec) & ((NUM_CH'(1) << irq_chan) - NUM_CH'(1))) == '0));

  // R6
  push_value_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> stack_pc == ($past(insn_addr) + ($past(insn_long) ? ADDR_W'(2) : ADDR_W'(1))));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_req |-> ($stable(stack_pc) && $stable(irq_chan)));

endmodule

bind addr_watch_irq awi_chk #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (.*);

// File: tb/addr_watch_irq_test.sv
`timescale 1ns/1ps
module addr_watch_irq_test;
  localparam int AW = 20;

  logic          clk = 0;
  logic          rst = 1;
  logic          cfg_wr = 0;
  logic [1:0]    cfg_sel = 2'd3;
  logic [AW-1:0] cfg_wdata = '0;
  logic [AW-1:0] cfg_rdata;
  logic          insn_start = 0;
  logic [AW-1:0] insn_addr = '0;
  logic          insn_long = 0;
  logic          irq_req;
  logic          irq_chan;
  logic [AW-1:0] stack_pc;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [AW-1:0] m_addr [2];
  logic [1:0]    m_en;
  logic          m_chan;
  logic [AW-1:0] m_pc;

  always #2 clk = ~clk;

  addr_watch_irq uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .insn_start(insn_start), .insn_addr(insn_addr),
    .insn_long(insn_long), .irq_req(irq_req), .irq_chan(irq_chan), .stack_pc(stack_pc)
  );

  function automatic logic [AW-1:0] exp_read(input logic [1:0] s);
    case (s)
      2'd0: return m_addr[0];
      2'd1: return m_addr[1];
      2'd2: return {{(AW-2){1'b0}}, m_en};
      default: return '0;
    endcase
  endfunction

  function automatic logic [AW-1:0] exp_push(input logic [AW-1:0] a, input logic lng);
    return a + (lng ? AW'(2) : AW'(1));
  endfunction

  task automatic check(input string req, input string what, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, predict from the pre-edge model, check after the edge
  task automatic step(input string tag, input logic st, input logic [AW-1:0] a,
                      input logic lng, input logic wr, input logic [1:0] sel,
                      input logic [AW-1:0] wd);
    logic h0, h1, e_irq;
    logic [AW-1:0] e_rd;
    @(negedge clk);
    insn_start = st; insn_addr = a; insn_long = lng;
    cfg_wr = wr; cfg_sel = sel; cfg_wdata = wd;
    h0 = st && m_en[0] && (a == m_addr[0]);
    h1 = st && m_en[1] && (a == m_addr[1]);
    e_irq = h0 | h1;
    e_rd = exp_read(sel);
    if (e_irq) begin
      m_chan = h0 ? 1'b0 : 1'b1;
      m_pc = exp_push(a, lng);
    end
    if (wr) begin
      if (sel == 2'd0) m_addr[0] = wd;
      else if (sel == 2'd1) m_addr[1] = wd;
      else if (sel == 2'd2) m_en = wd[1:0];
    end
    @(posedge clk); #1;
    check(tag, "irq_req", AW'(irq_req), AW'(e_irq));
    check("R5", "irq_chan", AW'(irq_chan), AW'(m_chan));
    check("R6", "stack_pc", stack_pc, m_pc);
    check("R7", "cfg_rdata", cfg_rdata, e_rd);
  endtask

  task automatic wreg(input logic [1:0] sel, input logic [AW-1:0] wd);
    step("R2", 0, '0, 0, 1, sel, wd);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [AW-1:0] a;
    m_addr[0] = '0; m_addr[1] = '0; m_en = '0; m_chan = 0; m_pc = '0;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #0;
    // R1: reset state on every output and every register read
    @(posedge clk); #1;
    check("R1", "irq_req", AW'(irq_req), '0);
    check("R1", "stack_pc", stack_pc, '0);
    step("R1", 0, '0, 0, 0, 2'd0, '0);
    step("R1", 0, '0, 0, 0, 2'd1, '0);
    step("R1", 0, '0, 0, 0, 2'd2, '0);
    step("R1", 1, '0, 0, 0, 2'd2, '0);   // zero address, both disabled

    // R3: matching address with channel disabled
    wreg(2'd0, 20'h12345);
    step("R3", 1, 20'h12345, 0, 0, 2'd3, '0);
    // R7: enable register ignores upper bits
    wreg(2'd2, 20'hFFFFD);                // enables channel 0 only
    step("R7", 0, '0, 0, 0, 2'd2, '0);
    // R2 / R6 short offset
    step("R2", 1, 20'h12345, 0, 0, 2'd3, '0);
    step("R9", 0, 20'h12345, 1, 0, 2'd3, '0); // R9 hold, R4 no strobe
    // R6 long offset
    step("R6", 1, 20'h12345, 1, 0, 2'd3, '0);
    // R4: strobe low with matching address
    step("R4", 0, 20'h12345, 0, 0, 2'd3, '0);
    // R6 wrap at the top of the address space on channel 1
    wreg(2'd1, 20'hFFFFF);
    wreg(2'd2, 20'h00002);
    step("R6", 1, 20'hFFFFF, 1, 0, 2'd3, '0);
    step("R3", 1, 20'h12345, 0, 0, 2'd3, '0); // channel 0 now disabled
    // R5: both channels on one address
    wreg(2'd0, 20'hABCDE);
    wreg(2'd1, 20'hABCDE);
    wreg(2'd2, 20'h00003);
    step("R5", 1, 20'hABCDE, 0, 0, 2'd3, '0);
    // R8: retarget channel 0 in the strobe cycle
    step("R8", 1, 20'h00777, 0, 1, 2'd0, 20'h00777);
    step("R8", 1, 20'h00777, 1, 0, 2'd3, '0);
    // R8: disable in the strobe cycle still fires on old enable
    step("R8", 1, 20'h00777, 0, 1, 2'd2, 20'h00000);
    step("R3", 1, 20'h00777, 0, 0, 2'd3, '0);

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [1:0] pick;
      logic [1:0] sel;
      logic wr;
      logic [AW-1:0] wd;
      pick = 2'($urandom_range(0, 3));
      case (pick)
        2'd0: a = m_addr[0];
        2'd1: a = m_addr[1];
        default: a = AW'($urandom());
      endcase
      wr = ($urandom_range(0, 7) == 0);
      sel = 2'($urandom_range(0, 3));
      wd = ($urandom_range(0, 1) == 1) ? m_addr[$urandom_range(0, 1)] : AW'($urandom());
      step("R2", 1'($urandom_range(0, 3) != 0), a, 1'($urandom()), wr, sel, wd);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule